// File: doc/BRIEF.md
# Sleep State and Wake Controller

This block sequences a system between the working state S0 and the sleep states S1, S3, S4 and S5. Software picks a target with a two-bit request code and a one-cycle go strobe. The controller then holds the active-low sleep controls that fit that state: a clock-stop request and an optional processor-sleep request for S1, and graded power-removal outputs for the deeper states. Each deeper state removes more power. A request that arrives while the block is already asleep is dropped.

Wake sources are level inputs packed into one vector. Bit 0 is the power button and bit 1 is the RTC alarm. The sixteen general-purpose inputs follow, then four USB sources, the ring indicator and two PME sources. A rising edge on a source sets its sticky status bit, and software clears that bit by writing 1. While asleep, any status bit that is enabled and eligible brings the system back to S0 and sets a sticky wake flag. The power button needs no enable bit. Eligibility depends on the sleep state: a general-purpose input marked as core-well wakes only from S1, and the PME sources cannot wake from an S5 that was entered after a power failure or a button override. While battery-low is asserted, no wake happens. Events that arrive in that time stay in their status bits, and the wake follows once battery-low drops.

All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready interface and no back-pressure to define.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset the state code is 0 (S0), all five sleep outputs are high, and every status bit and the wake flag are 0.
- R2: A go strobe in S0 with request code 0 gives state code 1 (S1) one clock later. In S1 `stpclk_n` is low and `cpuslp_n` is low only when `cpuslp_cfg` is 1. All other sleep outputs stay high, and no output changes before that clock edge.
- R3: Request code 1 gives state code 3 (S3). In S3 only `slp_s3_n` is low.
- R4: Request code 2 gives state code 4 (S4). In S4 `slp_s3_n` and `slp_s4_n` are low.
- R5: Request code 3 gives state code 5 (S5). In S5 `slp_s3_n`, `slp_s4_n` and `slp_s5_n` are all low.
- R6: A rising edge on `wake_src[i]` sets `wake_sts[i]` one clock later. The bit stays set after the source falls. A 1 on `sts_clr[i]` clears it. A new edge in the same cycle as the clear wins, and the bit stays set.
- R7: While asleep, a set status bit that is eligible returns the state to S0 on the next clock. All sleep outputs go high in that same cycle and `wak_sts` is set. `wak_clr` clears `wak_sts`. The power button (bit 0) is always eligible.
- R8: Sources 1 to 24 wake only when their enable bit `wake_en[i]` is 1.
- R9: While `batt_low` is 1, no wake happens, including from the power button. A status bit set during that time causes the wake on the first clock after `batt_low` falls.
- R10: Input bit 2+j, which is general-purpose input j, cannot wake from S3, S4 or S5 when `core_well[j]` is 1. It can wake from S1.
- R11: An S5 entry with `pwr_fail_entry` high at the go strobe makes the PME bits 23 and 24 ineligible for that S5 stay. The next entry starts without this restriction.
- R12: A go strobe while the state is not S0 leaves the state and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_go | input | 1 | One-cycle request to enter sleep |
| sleep_req | input | 2 | Target state: 0=S1, 1=S3, 2=S4, 3=S5 |
| pwr_fail_entry | input | 1 | S5 entry is caused by power failure or button override |
| cpuslp_cfg | input | 1 | Also assert the processor-sleep output in S1 |
| batt_low | input | 1 | Battery low, holds off every wake |
| wake_src | input | 25 | Wake source levels (0 button, 1 RTC, 2-17 GPI, 18-21 USB, 22 ring, 23-24 PME) |
| wake_en | input | 24 | Enables for sources 1 to 24, indexed [24:1] |
| core_well | input | 16 | Per GPI: input sits in the core well |
| sts_clr | input | 25 | Write-1-to-clear pulses for `wake_sts` |
| wak_clr | input | 1 | Clear pulse for `wak_sts` |
| stpclk_n | output | 1 | Clock-stop request, active low |
| cpuslp_n | output | 1 | Processor sleep, active low |
| slp_s3_n | output | 1 | Non-critical power off, active low |
| slp_s4_n | output | 1 | Memory power off, active low |
| slp_s5_n | output | 1 | Soft-off, active low |
| pm_state | output | 3 | Current state code: 0, 1, 3, 4 or 5 |
| wake_sts | output | 25 | Sticky per-source edge status |
| wak_sts | output | 1 | Sticky flag: a wake happened |

## Verification
Every request code is tried with the processor-sleep option both off and on. This separates the output pattern of each state and the S1 option. Each of the 25 sources is then fired alone, from each sleep state, with its enable both set and clear. S5 is tried with and without the power-fail cause. The expected wake or stay follows from the source class, the core-well mask 0xA5A5 and the cause flag, so this sweep tells the enable, core-well and PME rules apart. Separate sequences cover battery-low hold-off with a wake after release, the sticky status with clear and the same-cycle set-wins case, and a go strobe that arrives while asleep.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    ST_S0 = 3'd0,
    ST_S1 = 3'd1,
    ST_S3 = 3'd3,
    ST_S4 = 3'd4,
    ST_S5 = 3'd5
  } pm_state_e;

  localparam logic [1:0] REQ_S5 = 2'd3;

  function automatic pm_state_e req_to_state(input logic [1:0] req);
    case (req)
      2'd0:    return ST_S1;
      2'd1:    return ST_S3;
      2'd2:    return ST_S4;
      default: return ST_S5;
    endcase
  endfunction
endpackage

// File: rtl/pm_wake_status.sv
module pm_wake_status #(
  parameter int NSRC = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] sts
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] rise;

  assign rise = src & ~src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      sts   <= '0;
    end else begin
      src_q <= src;
      sts   <= (sts & ~clr) | rise;
    end
  end
endmodule

// File: rtl/pm_wake_qual.sv
module pm_wake_qual
  import pm_pkg::*;
#(
  parameter int NGPI = 16,
  parameter int NUSB = 4,
  parameter int NPME = 2,
  localparam int NSRC = 3 + NGPI + NUSB + NPME
) (
  input  logic [NSRC-1:0] sts,
  input  logic [NSRC-1:1] en,
  input  logic [NGPI-1:0] core_well,
  input  pm_state_e       state,
  input  logic            s5_fail,
  output logic            wake_hit
);
  localparam int GPI_LO = 2;
  localparam int PME_LO = GPI_LO + NGPI + NUSB + 1;

  logic [NSRC-1:0] gate;
  logic core_off;
  logic pme_block;

  assign core_off  = (state != ST_S1);
  assign pme_block = (state == ST_S5) && s5_fail;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == 0) begin : g_btn
      assign gate[i] = 1'b1;
    end else if (i >= GPI_LO && i < GPI_LO + NGPI) begin : g_gpi
      assign gate[i] = en[i] & ~(core_well[i-GPI_LO] & core_off);
    end else if (i >= PME_LO) begin : g_pme
      assign gate[i] = en[i] & ~pme_block;
    end else begin : g_plain
      assign gate[i] = en[i];
    end
  end

  assign wake_hit = |(sts & gate);
endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [1:0] req,
  input  logic       fail_in,
  input  logic       cpuslp_cfg,
  input  logic       wake_hit,
  input  logic       batt_low,
  input  logic       wak_clr,
  output pm_state_e  state,
  output logic       s5_fail,
  output logic       wak_sts,
  output logic       stpclk_n,
  output logic       cpuslp_n,
  output logic       slp_s3_n,
  output logic       slp_s4_n,
  output logic       slp_s5_n
);
  logic do_wake;

  assign do_wake = (state != ST_S0) && wake_hit && !batt_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_S0;
      s5_fail <= 1'b0;
      wak_sts <= 1'b0;
    end else begin
      if (state == ST_S0 && go) begin
        state   <= req_to_state(req);
        s5_fail <= (req == REQ_S5) && fail_in;
      end else if (do_wake) begin
        state   <= ST_S0;
      end
      wak_sts <= do_wake | (wak_sts & ~wak_clr);
    end
  end

  always_comb begin
    stpclk_n = 1'b1;
    cpuslp_n = 1'b1;
    slp_s3_n = 1'b1;
    slp_s4_n = 1'b1;
    slp_s5_n = 1'b1;
    case (state)
      ST_S1: begin
        stpclk_n = 1'b0;
        cpuslp_n = ~cpuslp_cfg;
      end
      ST_S3: slp_s3_n = 1'b0;
      ST_S4: begin
        slp_s3_n = 1'b0;
        slp_s4_n = 1'b0;
      end
      ST_S5: begin
        slp_s3_n = 1'b0;
        slp_s4_n = 1'b0;
        slp_s5_n = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import pm_pkg::*;
#(
  parameter int NGPI = 16,
  parameter int NUSB = 4,
  parameter int NPME = 2,
  localparam int NSRC = 3 + NGPI + NUSB + NPME
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_go,
  input  logic [1:0]      sleep_req,
  input  logic            pwr_fail_entry,
  input  logic            cpuslp_cfg,
  input  logic            batt_low,
  input  logic [NSRC-1:0] wake_src,
  input  logic [NSRC-1:1] wake_en,
  input  logic [NGPI-1:0] core_well,
  input  logic [NSRC-1:0] sts_clr,
  input  logic            wak_clr,
  output logic            stpclk_n,
  output logic            cpuslp_n,
  output logic            slp_s3_n,
  output logic            slp_s4_n,
  output logic            slp_s5_n,
  output logic [2:0]      pm_state,
  output logic [NSRC-1:0] wake_sts,
  output logic            wak_sts
);
  pm_state_e st;
  logic      s5_fail;
  logic      wake_hit;

  pm_wake_status #(.NSRC(NSRC)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (wake_src),
    .clr   (sts_clr),
    .sts   (wake_sts)
  );

  pm_wake_qual #(.NGPI(NGPI), .NUSB(NUSB), .NPME(NPME)) u_qual (
    .sts       (wake_sts),
    .en        (wake_en),
    .core_well (core_well),
    .state     (st),
    .s5_fail   (s5_fail),
    .wake_hit  (wake_hit)
  );

  pm_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (sleep_go),
    .req        (sleep_req),
    .fail_in    (pwr_fail_entry),
    .cpuslp_cfg (cpuslp_cfg),
    .wake_hit   (wake_hit),
    .batt_low   (batt_low),
    .wak_clr    (wak_clr),
    .state      (st),
    .s5_fail    (s5_fail),
    .wak_sts    (wak_sts),
    .stpclk_n   (stpclk_n),
    .cpuslp_n   (cpuslp_n),
    .slp_s3_n   (slp_s3_n),
    .slp_s4_n   (slp_s4_n),
    .slp_s5_n   (slp_s5_n)
  );

  assign pm_state = st;
endmodule

// File: rtl/pm_wake_chk.sv
module pm_wake_chk #(
  parameter int NSRC = 25
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sleep_go,
  input logic [1:0]      sleep_req,
  input logic            batt_low,
  input logic [NSRC-1:0] wake_src,
  input logic [NSRC-1:0] wake_sts,
  input logic            stpclk_n,
  input logic            cpuslp_n,
  input logic            slp_s3_n,
  input logic            slp_s4_n,
  input logic            slp_s5_n,
  input logic [2:0]      pm_state,
  input logic            wak_sts
);
  logic [NSRC-1:0] src_seen;
  logic [NSRC-1:0] rise;
  logic            was_asleep;

  assign rise = wake_src & ~src_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_seen   <= '0;
      was_asleep <= 1'b0;
    end else begin
      src_seen   <= wake_src;
      was_asleep <= (pm_state != 3'd0);
    end
  end

  // R2
  s1_clock_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_go && pm_state == 3'd0 && sleep_req == 2'd0) |=> (!stpclk_n && slp_s3_n));

  // R5
  s5_all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_go && pm_state == 3'd0 && sleep_req == 2'd3) |=> (!slp_s3_n && !slp_s4_n && !slp_s5_n));

  // R6
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((wake_sts & $past(rise)) == $past(rise)));

  // R7
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (was_asleep && pm_state == 3'd0) |->
      (wak_sts && stpclk_n && cpuslp_n && slp_s3_n && slp_s4_n && slp_s5_n));

  // R9
  batt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_low && pm_state != 3'd0) |=> (pm_state != 3'd0));
endmodule

bind sleep_wake_ctrl pm_wake_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_go  (sleep_go),
  .sleep_req (sleep_req),
  .batt_low  (batt_low),
  .wake_src  (wake_src),
  .wake_sts  (wake_sts),
  .stpclk_n  (stpclk_n),
  .cpuslp_n  (cpuslp_n),
  .slp_s3_n  (slp_s3_n),
  .slp_s4_n  (slp_s4_n),
  .slp_s5_n  (slp_s5_n),
  .pm_state  (pm_state),
  .wak_sts   (wak_sts)
);

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 25;
  localparam logic [15:0] CORE_MASK = 16'hA5A5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_go = 1'b0;
  logic [1:0]    sleep_req = 2'd0;
  logic          pwr_fail_entry = 1'b0;
  logic          cpuslp_cfg = 1'b0;
  logic          batt_low = 1'b0;
  logic [NS-1:0] wake_src = '0;
  logic [NS-1:0] en_full = '0;
  logic [NS-1:1] wake_en;
  logic [15:0]   core_well = CORE_MASK;
  logic [NS-1:0] sts_clr = '0;
  logic          wak_clr = 1'b0;
  logic          stpclk_n, cpuslp_n, slp_s3_n, slp_s4_n, slp_s5_n;
  logic [2:0]    pm_state;
  logic [NS-1:0] wake_sts;
  logic          wak_sts;

  int n_cmp = 0;
  int n_bad = 0;

  assign wake_en = en_full[NS-1:1];

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_wake_ctrl i_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_go(sleep_go), .sleep_req(sleep_req),
    .pwr_fail_entry(pwr_fail_entry), .cpuslp_cfg(cpuslp_cfg), .batt_low(batt_low),
    .wake_src(wake_src), .wake_en(wake_en), .core_well(core_well),
    .sts_clr(sts_clr), .wak_clr(wak_clr),
    .stpclk_n(stpclk_n), .cpuslp_n(cpuslp_n), .slp_s3_n(slp_s3_n),
    .slp_s4_n(slp_s4_n), .slp_s5_n(slp_s5_n), .pm_state(pm_state),
    .wake_sts(wake_sts), .wak_sts(wak_sts)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  function automatic logic [4:0] outs();
    return {stpclk_n, cpuslp_n, slp_s3_n, slp_s4_n, slp_s5_n};
  endfunction

  function automatic logic [2:0] code_of(input int t);
    case (t)
      0: return 3'd1;
      1: return 3'd3;
      2: return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  task automatic clear_all();
    wake_src = '0;
    sts_clr  = '1;
    wak_clr  = 1'b1;
    nxt();
    sts_clr  = '0;
    wak_clr  = 1'b0;
  endtask

  task automatic go(input int t, input logic f);
    sleep_req = t[1:0];
    pwr_fail_entry = f;
    sleep_go = 1'b1;
    nxt();
    sleep_go = 1'b0;
    pwr_fail_entry = 1'b0;
  endtask

  task automatic btn_wake(input string req);
    wake_src[0] = 1'b1;
    nxt();
    nxt();
    chk(req, {29'd0, pm_state}, 32'd0);
    wake_src[0] = 1'b0;
  endtask

  initial begin
    repeat (3) nxt();
    rst_n = 1'b1;
    nxt();
    // R1 reset state
    chk("R1 outputs", {27'd0, outs()}, 32'h1F);
    chk("R1 state", {29'd0, pm_state}, 32'd0);
    chk("R1 wake_sts", {7'd0, wake_sts}, 32'd0);
    chk("R1 wak_sts", {31'd0, wak_sts}, 32'd0);

    // R2..R5 output patterns for every request code, with and without CPU sleep
    for (int t = 0; t < 4; t++) begin
      for (int c = 0; c < 2; c++) begin
        logic [4:0] exp_o;
        clear_all();
        cpuslp_cfg = c[0];
        sleep_req = t[1:0];
        sleep_go = 1'b1;
        #1;
        chk("R2 no change before edge", {27'd0, outs()}, 32'h1F);
        nxt();
        sleep_go = 1'b0;
        case (t)
          0: exp_o = {1'b0, ~c[0], 3'b111};
          1: exp_o = 5'b11011;
          2: exp_o = 5'b11001;
          default: exp_o = 5'b11000;
        endcase
        chk(t == 0 ? "R2 S1 outputs" : t == 1 ? "R3 S3 outputs" :
            t == 2 ? "R4 S4 outputs" : "R5 S5 outputs", {27'd0, outs()}, {27'd0, exp_o});
        chk("R2-state code", {29'd0, pm_state}, {29'd0, code_of(t)});
        btn_wake("R7 button wake");
        chk("R7 outputs high on wake", {27'd0, outs()}, 32'h1F);
        chk("R7 wak_sts set", {31'd0, wak_sts}, 32'd1);
      end
    end
    cpuslp_cfg = 1'b0;

    // R7 wak_sts clear
    wak_clr = 1'b1;
    nxt();
    wak_clr = 1'b0;
    chk("R7 wak_clr", {31'd0, wak_sts}, 32'd0);

    // R6 sticky, clear, set wins
    clear_all();
    wake_src[5] = 1'b1;
    nxt();
    chk("R6 edge sets", {31'd0, wake_sts[5]}, 32'd1);
    wake_src[5] = 1'b0;
    nxt();
    chk("R6 sticky", {31'd0, wake_sts[5]}, 32'd1);
    sts_clr[5] = 1'b1;
    nxt();
    sts_clr[5] = 1'b0;
    chk("R6 clear", {31'd0, wake_sts[5]}, 32'd0);
    wake_src[7] = 1'b1;
    nxt();
    wake_src[7] = 1'b0;
    nxt();
    wake_src[7] = 1'b1;
    sts_clr[7] = 1'b1;
    nxt();
    sts_clr[7] = 1'b0;
    chk("R6 set wins over clear", {31'd0, wake_sts[7]}, 32'd1);

    // Sweep: every source, every state, enable on/off, S5 cause on/off
    for (int idx = 0; idx < NS; idx++) begin
      for (int t = 0; t < 4; t++) begin
        for (int e = 0; e < 2; e++) begin
          for (int f = 0; f < 2; f++) begin
            logic elig;
            string tag;
            if (f == 1 && t != 3) continue;
            clear_all();
            en_full = '0;
            if (e == 1) en_full[idx] = 1'b1;
            go(t, f[0]);
            chk("R12-entry state", {29'd0, pm_state}, {29'd0, code_of(t)});
            wake_src[idx] = 1'b1;
            nxt();
            chk("R6 source status", {31'd0, wake_sts[idx]}, 32'd1);
            nxt();
            elig = 1'b1;
            tag = "R7 wake";
            if (idx != 0) begin
              if (e == 0) begin
                elig = 1'b0; tag = "R8 disabled";
              end else if (idx >= 2 && idx < 18 && CORE_MASK[idx-2] && t != 0) begin
                elig = 1'b0; tag = "R10 core-well";
              end else if (idx >= 23 && t == 3 && f == 1) begin
                elig = 1'b0; tag = "R11 PME after fail";
              end
            end
            chk(tag, {29'd0, pm_state}, elig ? 32'd0 : {29'd0, code_of(t)});
            if (!elig) btn_wake("R7 fallback button");
            wake_src = '0;
          end
        end
      end
    end
    en_full = '0;

    // R9 battery low holds off, wake after release
    clear_all();
    go(1, 1'b0);
    batt_low = 1'b1;
    wake_src[0] = 1'b1;
    repeat (4) nxt();
    chk("R9 held in S3", {29'd0, pm_state}, 32'd3);
    chk("R9 no wak_sts", {31'd0, wak_sts}, 32'd0);
    wake_src[0] = 1'b0;
    batt_low = 1'b0;
    nxt();
    chk("R9 wake after release", {29'd0, pm_state}, 32'd0);

    // R12 go while asleep ignored
    clear_all();
    go(1, 1'b0);
    go(3, 1'b0);
    chk("R12 state kept", {29'd0, pm_state}, 32'd3);
    chk("R12 outputs kept", {27'd0, outs()}, 32'h1B);
    btn_wake("R12 wake after ignored go");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule